// File: doc/BRIEF.md
# Machine Timer and Inter-Hart Software Interrupt Unit

This unit holds one 64-bit real-time counter shared by every hart of a small multi-hart system. It also holds, for each hart, a 64-bit compare value and a single software-interrupt bit. It drives two level outputs per hart. The timer-pending output is high while the shared counter has reached or passed that hart's compare value. The software-pending output follows the hart's software bit.

Software reaches all state through a word-wide register port with an address, a write strobe, write data and combinational read data. The only way to clear a pending timer interrupt is to write a compare value that lies beyond the counter. The only way to raise or drop a software interrupt is to write the software word. Any hart may write any other hart's software word, and this is how one hart interrupts another.

The counter advances on a separate timebase strobe rather than on every bus clock. Its counting rate is therefore set by the system and not by the bus frequency.

Top module: `hart_timer_irq_unit`

## Requirements
- R1: After reset the counter reads zero, every software bit reads zero, and every compare register reads all ones in both halves. Both `timer_irq` and `soft_irq` are all zero.
- R2: The counter goes up by exactly one on each clock edge where `tick_en` is high and no counter half is written. It holds its value on edges where `tick_en` is low.
- R3: The counter's bits 31:0 are at offset 0xBFF8 and its bits 63:32 are at 0xBFFC. Both halves can be read and written. A write replaces only the addressed half. A counter write on the same edge as a tick wins, and that tick is lost.
- R4: Hart h's compare register has bits 31:0 at 0x4000+8h and bits 63:32 at 0x4004+8h. `timer_irq[h]` is high in the cycle after any register change that leaves the counter unsigned-greater-than-or-equal to the compare value, including exact equality.
- R5: Writing a compare value above the counter drops `timer_irq[h]` after the write edge. Without a bus write or a tick, the timer outputs keep their level.
- R6: Hart h's software word is at offset 4h. A write copies data bit 0 into the software bit, and `soft_irq[h]` shows the new value from the following cycle. Bits 31:1 read as zero and ignore writes.
- R7: A write to one hart's software word or compare register changes only that hart's outputs. The other harts' outputs are unchanged.
- R8: Reads of unmapped offsets return zero. Unmapped offsets include misaligned offsets and offsets of harts beyond `NUM_HARTS`. Writes to them change no register.
- R9: When a tick occurs with the counter's bits 31:0 at 0xFFFFFFFF, bits 31:0 wrap to zero and a carry goes into bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timebase strobe; one counter increment per high cycle |
| bus_addr | input | 16 | Byte offset of the register word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| timer_irq | output | NUM_HARTS | Per-hart timer-pending level |
| soft_irq | output | NUM_HARTS | Per-hart software-pending level |

## Verification
The comparison is driven one tick at a time up to the compare value. This separates the at-or-past rule from a strictly-past rule, and it catches an output that changes one cycle late. Compare values are written one half at a time, so an intermediate mixed value that must not fire is also exercised.

The counter is preloaded just below the 32-bit boundary and then ticked across it, which exposes a lost carry. A counter write is applied on the same edge as a tick, which exposes a wrong priority. The software words are written with all-ones and with bit 0 clear, which separates bit-0 decoding from decoding of any nonzero value. Writes to neighbouring misaligned and out-of-range offsets must leave the software bits and compare values unchanged.

// File: rtl/htiu_pkg.sv
// Shared constants for the machine timer unit: register widths and the
// byte offsets of each register region. Assumes a 16-bit byte address.
package htiu_pkg;
    localparam int ADDR_W    = 16;
    localparam int HALF_W    = 32;
    localparam int CNT_W     = 2 * HALF_W;

    localparam logic [ADDR_W-1:0] SOFT_BASE = 16'h0000;
    localparam logic [ADDR_W-1:0] CMP_BASE  = 16'h4000;
    localparam logic [ADDR_W-1:0] CNT_LO    = 16'hBFF8;
    localparam logic [ADDR_W-1:0] CNT_HI    = 16'hBFFC;

    localparam int SOFT_STRIDE = 4;
    localparam int CMP_STRIDE  = 8;

    typedef struct packed {
        logic lo;
        logic hi;
    } half_sel_t;
endpackage

// File: rtl/htiu_counter.sv
// Shared 64-bit real-time counter. Counts one per cycle of tick_en.
// A bus write to either half takes priority over a tick on the same edge.
// Assumes at most one half is written per cycle.
module htiu_counter
    import htiu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  half_sel_t        wr_sel,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  count_o
);
    logic [CNT_W-1:0] count_q;

    // Counter register: reset, half write, or increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (wr_sel.lo || wr_sel.hi) begin
            if (wr_sel.lo) count_q[HALF_W-1:0]     <= wdata;
            if (wr_sel.hi) count_q[CNT_W-1:HALF_W] <= wdata;
        end else if (tick_en) begin
            count_q <= count_q + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/htiu_hart_slot.sv
// Per-hart state: one compare register and one software-interrupt bit,
// with their address decode, read-back and pending outputs.
// Assumes word-aligned accesses; misaligned offsets never match.
module htiu_hart_slot
    import htiu_pkg::*;
#(
    parameter int HART_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [HALF_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count_i,
    output logic [HALF_W-1:0] rdata_o,
    output logic              timer_irq_o,
    output logic              soft_irq_o
);
    localparam logic [ADDR_W-1:0] SOFT_ADDR = ADDR_W'(int'(SOFT_BASE) + SOFT_STRIDE * HART_IDX);
    localparam logic [ADDR_W-1:0] CMP_LO    = ADDR_W'(int'(CMP_BASE) + CMP_STRIDE * HART_IDX);
    localparam logic [ADDR_W-1:0] CMP_HI    = ADDR_W'(int'(CMP_BASE) + CMP_STRIDE * HART_IDX + 4);

    logic [CNT_W-1:0] cmp_q;
    logic             soft_q;
    logic             hit_soft, hit_lo, hit_hi;

    // Address match for this hart's three words
    always_comb begin
        hit_soft = (bus_addr == SOFT_ADDR);
        hit_lo   = (bus_addr == CMP_LO);
        hit_hi   = (bus_addr == CMP_HI);
    end

    // Compare register: all ones at reset so nothing is pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (bus_we) begin
            if (hit_lo) cmp_q[HALF_W-1:0]     <= bus_wdata;
            if (hit_hi) cmp_q[CNT_W-1:HALF_W] <= bus_wdata;
        end
    end

    // Software-interrupt bit: only data bit 0 is kept
    always_ff @(posedge clk) begin
        if (!rst_n)                 soft_q <= 1'b0;
        else if (bus_we && hit_soft) soft_q <= bus_wdata[0];
    end

    // Read-back of this hart's words, zero when not addressed
    always_comb begin
        rdata_o = '0;
        if (hit_soft)    rdata_o = {{(HALF_W-1){1'b0}}, soft_q};
        else if (hit_lo) rdata_o = cmp_q[HALF_W-1:0];
        else if (hit_hi) rdata_o = cmp_q[CNT_W-1:HALF_W];
    end

    assign timer_irq_o = (count_i >= cmp_q);
    assign soft_irq_o  = soft_q;
endmodule

// File: rtl/hart_timer_irq_unit.sv
// Top of the machine timer and inter-hart software interrupt unit.
// Holds the shared counter and one slot per hart, and merges read data.
// Assumes NUM_HARTS is small enough that all regions fit the 16-bit map.
module hart_timer_irq_unit
    import htiu_pkg::*;
#(
    parameter int NUM_HARTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic [15:0]          bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_HARTS-1:0] timer_irq,
    output logic [NUM_HARTS-1:0] soft_irq
);
    logic [CNT_W-1:0]  count_q;
    half_sel_t         cnt_wr;
    logic [HALF_W-1:0] slot_rdata [NUM_HARTS];

    // Counter half write selects
    always_comb begin
        cnt_wr.lo = bus_we && (bus_addr == CNT_LO);
        cnt_wr.hi = bus_we && (bus_addr == CNT_HI);
    end

    htiu_counter u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_sel  (cnt_wr),
        .wdata   (bus_wdata),
        .count_o (count_q)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        htiu_hart_slot #(.HART_IDX(h)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .bus_addr    (bus_addr),
            .bus_we      (bus_we),
            .bus_wdata   (bus_wdata),
            .count_i     (count_q),
            .rdata_o     (slot_rdata[h]),
            .timer_irq_o (timer_irq[h]),
            .soft_irq_o  (soft_irq[h])
        );
    end

    // Read data: counter halves or the OR of the hart slots
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CNT_LO)      bus_rdata = count_q[HALF_W-1:0];
        else if (bus_addr == CNT_HI) bus_rdata = count_q[CNT_W-1:HALF_W];
        else begin
            for (int h = 0; h < NUM_HARTS; h++) bus_rdata = bus_rdata | slot_rdata[h];
        end
    end
endmodule

// File: rtl/htiu_checker.sv
// Property checker for the timer unit, attached by bind. Observes the
// bus, the outputs and the shared counter register.
module htiu_checker
    import htiu_pkg::*;
#(
    parameter int NUM_HARTS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_en,
    input logic [15:0]          bus_addr,
    input logic                 bus_we,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [63:0]          count,
    input logic [NUM_HARTS-1:0] timer_irq,
    input logic [NUM_HARTS-1:0] soft_irq
);
    logic cnt_addr, soft_addr, cmp_addr, mapped;

    // Independent view of the register map
    always_comb begin
        cnt_addr  = (bus_addr == CNT_LO) || (bus_addr == CNT_HI);
        soft_addr = (int'(bus_addr) < SOFT_STRIDE * NUM_HARTS) && (bus_addr[1:0] == 2'b00);
        cmp_addr  = (int'(bus_addr) >= int'(CMP_BASE)) &&
                    (int'(bus_addr) < int'(CMP_BASE) + CMP_STRIDE * NUM_HARTS) &&
                    (bus_addr[1:0] == 2'b00);
        mapped    = cnt_addr || soft_addr || cmp_addr;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !(bus_we && cnt_addr)) |=> (count == $past(count) + 64'd1)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !(bus_we && cnt_addr)) |=> $stable(count)); // R2
    AST_CNT_WR_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CNT_LO) |=> (count[31:0] == $past(bus_wdata))); // R3
    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && !tick_en) |=> $stable(timer_irq)); // R5
    AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(soft_irq)); // R6
    AST_SOFT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        soft_addr |-> (bus_rdata[31:1] == 31'd0)); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == 32'd0)); // R8
endmodule

bind hart_timer_irq_unit htiu_checker #(.NUM_HARTS(NUM_HARTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .count     (count_q),
    .timer_irq (timer_irq),
    .soft_irq  (soft_irq)
);

// File: tb/tb_hart_timer_irq_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values, a monitor on the
// falling edge pops and compares them against the design outputs.
module tb_hart_timer_irq_unit;
    localparam int NH = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NH-1:0] timer_irq, soft_irq;

    int  vectors = 0;
    int  fails = 0;
    bit  done = 1'b0;

    typedef struct {
        int          kind;   // 0 read data, 1 timer lines, 2 soft lines
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    hart_timer_irq_unit #(.NUM_HARTS(NH)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .timer_irq(timer_irq), .soft_irq(soft_irq)
    );

    // Monitor: compare every queued item at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = 32'(timer_irq);
                default: act = 32'(soft_irq);
            endcase
            vectors++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input bit tk = 1'b0);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d; tick_en = tk;
        @(posedge clk); #1;
        bus_we = 1'b0; tick_en = 1'b0;
    endtask

    task automatic exp_rd(input logic [15:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        sb.push_back('{0, e, tag});
        @(negedge clk);
    endtask

    task automatic exp_line(input int kind, input logic [NH-1:0] e, input string tag);
        @(posedge clk); #1;
        sb.push_back('{kind, 32'(e), tag});
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #1;
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_en = 1'b0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        exp_rd(16'hBFF8, 32'h0, "R1 counter lo");
        exp_rd(16'hBFFC, 32'h0, "R1 counter hi");
        exp_rd(16'h4000, 32'hFFFF_FFFF, "R1 cmp0 lo");
        exp_rd(16'h400C, 32'hFFFF_FFFF, "R1 cmp1 hi");
        exp_rd(16'h0000, 32'h0, "R1 soft0");
        exp_line(1, 2'b00, "R1 timer lines");
        exp_line(2, 2'b00, "R1 soft lines");

        // R2 counting and holding
        ticks(10);
        exp_rd(16'hBFF8, 32'd10, "R2 ten ticks");
        repeat (5) @(posedge clk);
        exp_rd(16'hBFF8, 32'd10, "R2 hold without tick");

        // R4 compare with half-at-a-time write, equality fires
        wr(16'h4004, 32'h0);
        exp_line(1, 2'b00, "R4 mixed compare no fire");
        wr(16'h4000, 32'd20);
        exp_rd(16'h4000, 32'd20, "R4 cmp0 readback");
        ticks(9);
        exp_line(1, 2'b00, "R4 one below compare");
        ticks(1);
        exp_line(1, 2'b01, "R4 equal fires hart0 only (R7)");

        // R5 clearing by compare write
        wr(16'h4000, 32'd100);
        exp_line(1, 2'b00, "R5 cleared by compare write");
        ticks(5);
        exp_line(1, 2'b00, "R5 still clear below compare");

        // R4 / R7 hart1 compare to zero
        wr(16'h400C, 32'h0);
        wr(16'h4008, 32'h0);
        exp_line(1, 2'b10, "R7 hart1 fires, hart0 unchanged");

        // R6 / R7 software bits
        wr(16'h0004, 32'hFFFF_FFFF);
        exp_line(2, 2'b10, "R7 soft hart1 only");
        exp_rd(16'h0004, 32'h1, "R6 upper bits read zero");
        wr(16'h0004, 32'hFFFF_FFFE);
        exp_line(2, 2'b00, "R6 bit0 clear drops line");
        wr(16'h0000, 32'h1);
        exp_line(2, 2'b01, "R6 soft hart0 set");

        // R9 carry across halves
        wr(16'hBFF8, 32'hFFFF_FFFE);
        wr(16'hBFFC, 32'h5);
        exp_rd(16'hBFFC, 32'h5, "R3 hi half write");
        ticks(3);
        exp_rd(16'hBFF8, 32'h1, "R9 lo wraps");
        exp_rd(16'hBFFC, 32'h6, "R9 carry into hi");

        // R3 write beats tick
        wr(16'hBFF8, 32'h100, 1'b1);
        exp_rd(16'hBFF8, 32'h100, "R3 write over tick");
        exp_rd(16'hBFFC, 32'h6, "R3 other half kept");

        // R8 unmapped offsets
        wr(16'h0008, 32'h0);
        exp_line(2, 2'b01, "R8 out-of-range soft write ignored");
        exp_rd(16'h0008, 32'h0, "R8 out-of-range soft read");
        exp_rd(16'h0001, 32'h0, "R8 misaligned read");
        wr(16'h0001, 32'h0);
        exp_line(2, 2'b01, "R8 misaligned soft write ignored");
        wr(16'h4001, 32'h0);
        exp_rd(16'h4000, 32'd100, "R8 misaligned cmp write ignored");
        wr(16'h4010, 32'h0);
        exp_rd(16'h4010, 32'h0, "R8 hart2 cmp read");
        wr(16'hBFF0, 32'hDEAD);
        exp_rd(16'hBFF8, 32'h100, "R8 counter untouched");

        repeat (2) @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end
endmodule